// File: doc/BRIEF.md
# Store-to-Load Forwarding Lookup Unit

This block is a small store queue with a byte-wise search path that a two-stage load pipeline consults before trusting cache data. Each queue entry keeps a virtual address, a physical address, a per-byte mask of the bytes the store writes, up to sixteen data bytes, and two readiness flags: one for the address and one for the data. Addresses, masks and data arrive over separate write ports, so a store can be partly known at any moment.

A load presents both of its addresses, its 16-lane byte mask, a bit vector that marks which queue entries hold stores older than itself, and its queue pointer: the index of the first store younger than the load. In the same cycle the unit answers with a mask of bytes it can supply and a fast data-not-ready flag. One cycle later it gives the full forward mask, the forwarded bytes, and status flags. These flags tell the load to replay because an older store lacks its address or its data, each with the blocking store's index. A further flag asks for a flush when the virtual and physical searches disagree.

Top module: `stfwd_unit`

## Requirements
- R1: An address write sets the entry's virtual and physical address and marks its address ready. The next cycle's load search sees the new address and flag.
- R2: While `ld_valid` is low, `s1_fwd_mask` and `s1_data_inv` are zero. In the following cycle every stage-2 output is zero.
- R3: An entry matches a load only when all of the following hold: its bit in `ld_older` is set, its address is ready, virtual address bits [VA_W-1:4] equal those of the load, and its byte mask shares at least one set bit with `ld_mask`.
- R4: Each byte lane is owned by the youngest matching entry whose mask covers that lane. Queue order counts back from `ld_sq_ptr`-1, wrapping modulo the queue depth. A lane is forwarded (mask bit 1, data byte taken from the owner) only if the owner's data is ready. Lanes that are not forwarded read data zero.
- R5: `s1_fwd_mask` and `s1_data_inv` answer in the cycle of the request. `s2_fwd_mask` and `s2_data_inv` equal them one clock later, alongside the stage-2 data and flags.
- R6: If any matching entry lacks data, `s2_data_inv` is 1 and `s2_data_inv_idx` names the youngest such entry.
- R7: If any entry selected by `ld_older` lacks a ready address, `s2_addr_inv` is 1 and `s2_addr_inv_idx` names the youngest such entry. Both flags can be set together.
- R8: `s2_match_inv` is 1 when the set of entries matched using virtual addresses differs from the set matched using physical address bits [PA_W-1:4] under the same rules.
- R9: A mask write reaches its entry two clocks after the request. A load one cycle after the request still sees the old mask, and a load two cycles after sees the new one.
- R10: A free request clears the entry's address-ready and data-ready flags at the next clock.
- R11: Synchronous active-high reset clears all readiness flags and all stage-2 outputs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| st_addr_we | input | 1 | Address write enable |
| st_addr_idx | input | IDX_W | Entry index for the address write |
| st_vaddr | input | VA_W | Store virtual address |
| st_paddr | input | PA_W | Store physical address |
| st_mask_we | input | 1 | Mask write request |
| st_mask_idx | input | IDX_W | Entry index for the mask write |
| st_mask | input | 16 | Store byte mask |
| st_data_we | input | 1 | Data write enable |
| st_data_idx | input | IDX_W | Entry index for the data write |
| st_data | input | 128 | Store data bytes |
| st_free | input | 1 | Release an entry |
| st_free_idx | input | IDX_W | Entry index to release |
| ld_valid | input | 1 | Load request valid |
| ld_vaddr | input | VA_W | Load virtual address |
| ld_paddr | input | PA_W | Load physical address |
| ld_mask | input | 16 | Load byte mask |
| ld_older | input | NUM_ENTRIES | Entries holding stores older than the load |
| ld_sq_ptr | input | IDX_W | First store index younger than the load |
| s1_fwd_mask | output | 16 | Fast forward mask (same cycle) |
| s1_data_inv | output | 1 | Fast data-not-ready flag |
| s2_fwd_mask | output | 16 | Forward mask, next cycle |
| s2_fwd_data | output | 128 | Forwarded bytes, next cycle |
| s2_data_inv | output | 1 | Older matching store lacks data |
| s2_data_inv_idx | output | IDX_W | Youngest store lacking data |
| s2_addr_inv | output | 1 | Older store lacks an address |
| s2_addr_inv_idx | output | IDX_W | Youngest store lacking an address |
| s2_match_inv | output | 1 | Virtual and physical searches disagree |

## Verification
The bench aims first at overlapping stores of different age. If the priority scan ran the wrong way, or ignored the wrap past index zero, older bytes would win and lanes would carry the wrong data. It builds a partly ready queue, where one store has an address but no data and another is not yet addressed. A design with a wrong youngest-first pick, or one that suppresses one flag when the other is set, reports the wrong index or drops a flag. An aliased store that matches by virtual address alone must raise the flush flag. A mask write probed one and two cycles later exposes an off-by-one in the mask delay. A free followed by a search, and an idle request, show whether stale readiness or stray outputs leak through.

// File: rtl/stfwd_pkg.sv
package stfwd_pkg;

    localparam int LANES  = 16;
    localparam int LANE_W = 8;
    localparam int OFF_W  = $clog2(LANES);

    typedef logic [LANES-1:0]        lane_mask_t;
    typedef logic [LANES*LANE_W-1:0] lane_data_t;

    typedef struct packed {
        lane_mask_t mask;
        lane_data_t data;
    } fwd_result_t;

    typedef enum logic [1:0] {
        LANE_NONE  = 2'd0,
        LANE_READY = 2'd1,
        LANE_WAIT  = 2'd2
    } lane_state_e;

endpackage

// File: rtl/stfwd_store_array.sv
module stfwd_store_array
    import stfwd_pkg::*;
#(
    parameter int NUM_ENTRIES = 8,
    parameter int VA_W        = 16,
    parameter int PA_W        = 20,
    parameter int IDX_W       = $clog2(NUM_ENTRIES)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             addr_we,
    input  logic [IDX_W-1:0] addr_idx,
    input  logic [VA_W-1:0]  vaddr,
    input  logic [PA_W-1:0]  paddr,
    input  logic             mask_we,
    input  logic [IDX_W-1:0] mask_idx,
    input  lane_mask_t       mask_in,
    input  logic             data_we,
    input  logic [IDX_W-1:0] data_idx,
    input  lane_data_t       data_in,
    input  logic             free_we,
    input  logic [IDX_W-1:0] free_idx,
    output logic [VA_W-1:0]  ent_va   [NUM_ENTRIES],
    output logic [PA_W-1:0]  ent_pa   [NUM_ENTRIES],
    output lane_mask_t       ent_mask [NUM_ENTRIES],
    output lane_data_t       ent_data [NUM_ENTRIES],
    output logic             ent_av   [NUM_ENTRIES],
    output logic             ent_dv   [NUM_ENTRIES]
);

    typedef struct packed {
        logic             vld;
        logic [IDX_W-1:0] idx;
        lane_mask_t       mask;
    } mask_req_t;

    // the byte mask is staged once, so it lands on the second clock
    mask_req_t mreq_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            mreq_q <= '0;
        end else begin
            mreq_q <= '{vld: mask_we, idx: mask_idx, mask: mask_in};
        end
    end

    for (genvar i = 0; i < NUM_ENTRIES; i++) begin : g_entry
        localparam logic [IDX_W-1:0] MY_IDX = IDX_W'(i);

        always_ff @(posedge clk) begin
            if (rst) begin
                ent_av[i]   <= 1'b0;
                ent_dv[i]   <= 1'b0;
                ent_va[i]   <= '0;
                ent_pa[i]   <= '0;
                ent_mask[i] <= '0;
                ent_data[i] <= '0;
            end else begin
                if (free_we && free_idx == MY_IDX) begin
                    ent_av[i] <= 1'b0;
                    ent_dv[i] <= 1'b0;
                end
                if (addr_we && addr_idx == MY_IDX) begin
                    ent_av[i] <= 1'b1;
                    ent_va[i] <= vaddr;
                    ent_pa[i] <= paddr;
                end
                if (data_we && data_idx == MY_IDX) begin
                    ent_dv[i]   <= 1'b1;
                    ent_data[i] <= data_in;
                end
                if (mreq_q.vld && mreq_q.idx == MY_IDX) begin
                    ent_mask[i] <= mreq_q.mask;
                end
            end
        end
    end

endmodule

// File: rtl/stfwd_search.sv
module stfwd_search
    import stfwd_pkg::*;
#(
    parameter int NUM_ENTRIES = 8,
    parameter int VA_W        = 16,
    parameter int PA_W        = 20,
    parameter int IDX_W       = $clog2(NUM_ENTRIES)
) (
    input  logic                   ld_valid,
    input  logic [VA_W-1:0]        ld_vaddr,
    input  logic [PA_W-1:0]        ld_paddr,
    input  lane_mask_t             ld_mask,
    input  logic [NUM_ENTRIES-1:0] ld_older,
    input  logic [IDX_W-1:0]       ld_sq_ptr,
    input  logic [VA_W-1:0]        ent_va   [NUM_ENTRIES],
    input  logic [PA_W-1:0]        ent_pa   [NUM_ENTRIES],
    input  lane_mask_t             ent_mask [NUM_ENTRIES],
    input  lane_data_t             ent_data [NUM_ENTRIES],
    input  logic                   ent_av   [NUM_ENTRIES],
    input  logic                   ent_dv   [NUM_ENTRIES],
    output fwd_result_t            fwd,
    output logic                   data_inv,
    output logic [IDX_W-1:0]       data_inv_idx,
    output logic                   addr_inv,
    output logic [IDX_W-1:0]       addr_inv_idx,
    output logic                   match_inv
);

    logic [NUM_ENTRIES-1:0] va_hit;
    logic [NUM_ENTRIES-1:0] pa_hit;
    logic [NUM_ENTRIES-1:0] wait_data;
    logic [NUM_ENTRIES-1:0] wait_addr;

    for (genvar i = 0; i < NUM_ENTRIES; i++) begin : g_cmp
        logic sel;
        logic overlap;
        assign sel          = ld_valid & ld_older[i];
        assign overlap      = |(ent_mask[i] & ld_mask);
        assign va_hit[i]    = sel & ent_av[i] & overlap &
                              (ent_va[i][VA_W-1:OFF_W] == ld_vaddr[VA_W-1:OFF_W]);
        assign pa_hit[i]    = sel & ent_av[i] & overlap &
                              (ent_pa[i][PA_W-1:OFF_W] == ld_paddr[PA_W-1:OFF_W]);
        assign wait_data[i] = va_hit[i] & ~ent_dv[i];
        assign wait_addr[i] = sel & ~ent_av[i];
    end

    assign match_inv = |(va_hit ^ pa_hit);

    // scan from oldest to youngest; later (younger) hits overwrite earlier ones
    lane_state_e      lane_st [LANES];
    logic [IDX_W-1:0] pos;

    always_comb begin
        data_inv     = 1'b0;
        data_inv_idx = '0;
        addr_inv     = 1'b0;
        addr_inv_idx = '0;
        pos          = '0;
        fwd          = '0;
        for (int b = 0; b < LANES; b++) begin
            lane_st[b] = LANE_NONE;
        end
        for (int k = NUM_ENTRIES - 1; k >= 0; k--) begin
            pos = ld_sq_ptr - IDX_W'(k) - IDX_W'(1);
            if (wait_data[pos]) begin
                data_inv     = 1'b1;
                data_inv_idx = pos;
            end
            if (wait_addr[pos]) begin
                addr_inv     = 1'b1;
                addr_inv_idx = pos;
            end
            for (int b = 0; b < LANES; b++) begin
                if (va_hit[pos] && ent_mask[pos][b] && ld_mask[b]) begin
                    lane_st[b] = ent_dv[pos] ? LANE_READY : LANE_WAIT;
                    fwd.data[b*LANE_W +: LANE_W] =
                        ent_dv[pos] ? ent_data[pos][b*LANE_W +: LANE_W] : '0;
                end
            end
        end
        for (int b = 0; b < LANES; b++) begin
            fwd.mask[b] = (lane_st[b] == LANE_READY);
        end
    end

endmodule

// File: rtl/stfwd_resp_stage.sv
module stfwd_resp_stage
    import stfwd_pkg::*;
#(
    parameter int IDX_W = 3
) (
    input  logic             clk,
    input  logic             rst,
    input  fwd_result_t      fwd_in,
    input  logic             dinv_in,
    input  logic [IDX_W-1:0] didx_in,
    input  logic             ainv_in,
    input  logic [IDX_W-1:0] aidx_in,
    input  logic             minv_in,
    output fwd_result_t      fwd_q,
    output logic             dinv_q,
    output logic [IDX_W-1:0] didx_q,
    output logic             ainv_q,
    output logic [IDX_W-1:0] aidx_q,
    output logic             minv_q
);

    always_ff @(posedge clk) begin
        if (rst) begin
            fwd_q  <= '0;
            dinv_q <= 1'b0;
            didx_q <= '0;
            ainv_q <= 1'b0;
            aidx_q <= '0;
            minv_q <= 1'b0;
        end else begin
            fwd_q  <= fwd_in;
            dinv_q <= dinv_in;
            didx_q <= didx_in;
            ainv_q <= ainv_in;
            aidx_q <= aidx_in;
            minv_q <= minv_in;
        end
    end

endmodule

// File: rtl/stfwd_unit.sv
module stfwd_unit
    import stfwd_pkg::*;
#(
    parameter int NUM_ENTRIES = 8,
    parameter int VA_W        = 16,
    parameter int PA_W        = 20,
    localparam int IDX_W      = $clog2(NUM_ENTRIES)
) (
    input  logic                          clk,
    input  logic                          rst,
    input  logic                          st_addr_we,
    input  logic [IDX_W-1:0]              st_addr_idx,
    input  logic [VA_W-1:0]               st_vaddr,
    input  logic [PA_W-1:0]               st_paddr,
    input  logic                          st_mask_we,
    input  logic [IDX_W-1:0]              st_mask_idx,
    input  logic [LANES-1:0]              st_mask,
    input  logic                          st_data_we,
    input  logic [IDX_W-1:0]              st_data_idx,
    input  logic [LANES*LANE_W-1:0]       st_data,
    input  logic                          st_free,
    input  logic [IDX_W-1:0]              st_free_idx,
    input  logic                          ld_valid,
    input  logic [VA_W-1:0]               ld_vaddr,
    input  logic [PA_W-1:0]               ld_paddr,
    input  logic [LANES-1:0]              ld_mask,
    input  logic [NUM_ENTRIES-1:0]        ld_older,
    input  logic [IDX_W-1:0]              ld_sq_ptr,
    output logic [LANES-1:0]              s1_fwd_mask,
    output logic                          s1_data_inv,
    output logic [LANES-1:0]              s2_fwd_mask,
    output logic [LANES*LANE_W-1:0]       s2_fwd_data,
    output logic                          s2_data_inv,
    output logic [IDX_W-1:0]              s2_data_inv_idx,
    output logic                          s2_addr_inv,
    output logic [IDX_W-1:0]              s2_addr_inv_idx,
    output logic                          s2_match_inv
);

    logic [VA_W-1:0] ent_va   [NUM_ENTRIES];
    logic [PA_W-1:0] ent_pa   [NUM_ENTRIES];
    lane_mask_t      ent_mask [NUM_ENTRIES];
    lane_data_t      ent_data [NUM_ENTRIES];
    logic            ent_av   [NUM_ENTRIES];
    logic            ent_dv   [NUM_ENTRIES];

    fwd_result_t      srch_fwd;
    logic             srch_dinv;
    logic [IDX_W-1:0] srch_didx;
    logic             srch_ainv;
    logic [IDX_W-1:0] srch_aidx;
    logic             srch_minv;
    fwd_result_t      resp_fwd;

    stfwd_store_array #(
        .NUM_ENTRIES(NUM_ENTRIES), .VA_W(VA_W), .PA_W(PA_W), .IDX_W(IDX_W)
    ) u_array (
        .clk      (clk),
        .rst      (rst),
        .addr_we  (st_addr_we),
        .addr_idx (st_addr_idx),
        .vaddr    (st_vaddr),
        .paddr    (st_paddr),
        .mask_we  (st_mask_we),
        .mask_idx (st_mask_idx),
        .mask_in  (st_mask),
        .data_we  (st_data_we),
        .data_idx (st_data_idx),
        .data_in  (st_data),
        .free_we  (st_free),
        .free_idx (st_free_idx),
        .ent_va   (ent_va),
        .ent_pa   (ent_pa),
        .ent_mask (ent_mask),
        .ent_data (ent_data),
        .ent_av   (ent_av),
        .ent_dv   (ent_dv)
    );

    stfwd_search #(
        .NUM_ENTRIES(NUM_ENTRIES), .VA_W(VA_W), .PA_W(PA_W), .IDX_W(IDX_W)
    ) u_search (
        .ld_valid     (ld_valid),
        .ld_vaddr     (ld_vaddr),
        .ld_paddr     (ld_paddr),
        .ld_mask      (ld_mask),
        .ld_older     (ld_older),
        .ld_sq_ptr    (ld_sq_ptr),
        .ent_va       (ent_va),
        .ent_pa       (ent_pa),
        .ent_mask     (ent_mask),
        .ent_data     (ent_data),
        .ent_av       (ent_av),
        .ent_dv       (ent_dv),
        .fwd          (srch_fwd),
        .data_inv     (srch_dinv),
        .data_inv_idx (srch_didx),
        .addr_inv     (srch_ainv),
        .addr_inv_idx (srch_aidx),
        .match_inv    (srch_minv)
    );

    stfwd_resp_stage #(.IDX_W(IDX_W)) u_resp (
        .clk     (clk),
        .rst     (rst),
        .fwd_in  (srch_fwd),
        .dinv_in (srch_dinv),
        .didx_in (srch_didx),
        .ainv_in (srch_ainv),
        .aidx_in (srch_aidx),
        .minv_in (srch_minv),
        .fwd_q   (resp_fwd),
        .dinv_q  (s2_data_inv),
        .didx_q  (s2_data_inv_idx),
        .ainv_q  (s2_addr_inv),
        .aidx_q  (s2_addr_inv_idx),
        .minv_q  (s2_match_inv)
    );

    assign s1_fwd_mask = srch_fwd.mask;
    assign s1_data_inv = srch_dinv;
    assign s2_fwd_mask = resp_fwd.mask;
    assign s2_fwd_data = resp_fwd.data;

endmodule

// File: rtl/stfwd_unit_checker.sv
module stfwd_unit_checker #(
    parameter int NUM_ENTRIES = 8,
    parameter int IDX_W       = 3
) (
    input logic                   clk,
    input logic                   rst,
    input logic                   ld_valid,
    input logic [15:0]            ld_mask,
    input logic [NUM_ENTRIES-1:0] ld_older,
    input logic [15:0]            s1_fwd_mask,
    input logic                   s1_data_inv,
    input logic [15:0]            s2_fwd_mask,
    input logic [127:0]           s2_fwd_data,
    input logic                   s2_data_inv,
    input logic [IDX_W-1:0]       s2_data_inv_idx,
    input logic                   s2_addr_inv,
    input logic [IDX_W-1:0]       s2_addr_inv_idx,
    input logic                   s2_match_inv
);

    p_idle_fast_r2: assert property (@(posedge clk) disable iff (rst)
        !ld_valid |-> (s1_fwd_mask == '0 && !s1_data_inv));

    p_idle_late_r2: assert property (@(posedge clk) disable iff (rst)
        (!rst && !ld_valid) |=> (s2_fwd_mask == '0 && s2_fwd_data == '0 &&
                                 !s2_data_inv && !s2_addr_inv && !s2_match_inv));

    p_mask_follows_r5: assert property (@(posedge clk) disable iff (rst)
        !rst |=> (s2_fwd_mask == $past(s1_fwd_mask)));

    p_dinv_follows_r5: assert property (@(posedge clk) disable iff (rst)
        !rst |=> (s2_data_inv == $past(s1_data_inv)));

    p_lanes_in_load_r4: assert property (@(posedge clk) disable iff (rst)
        (s1_fwd_mask & ~ld_mask) == '0);

    p_dinv_is_older_r6: assert property (@(posedge clk) disable iff (rst)
        (!rst && ld_valid) |=>
            (!s2_data_inv || (($past(ld_older) >> s2_data_inv_idx) & 1) != 0));

    p_ainv_is_older_r7: assert property (@(posedge clk) disable iff (rst)
        (!rst && ld_valid) |=>
            (!s2_addr_inv || (($past(ld_older) >> s2_addr_inv_idx) & 1) != 0));

endmodule

bind stfwd_unit stfwd_unit_checker #(
    .NUM_ENTRIES(NUM_ENTRIES), .IDX_W(IDX_W)
) u_chk (
    .clk             (clk),
    .rst             (rst),
    .ld_valid        (ld_valid),
    .ld_mask         (ld_mask),
    .ld_older        (ld_older),
    .s1_fwd_mask     (s1_fwd_mask),
    .s1_data_inv     (s1_data_inv),
    .s2_fwd_mask     (s2_fwd_mask),
    .s2_fwd_data     (s2_fwd_data),
    .s2_data_inv     (s2_data_inv),
    .s2_data_inv_idx (s2_data_inv_idx),
    .s2_addr_inv     (s2_addr_inv),
    .s2_addr_inv_idx (s2_addr_inv_idx),
    .s2_match_inv    (s2_match_inv)
);

// File: tb/stfwd_unit_bench.sv
module stfwd_unit_bench;

    localparam int N    = 8;
    localparam int VA_W = 16;
    localparam int PA_W = 20;
    localparam int IW   = 3;

    logic clk = 1'b0;
    always #5 clk = ~clk;

    logic            rst;
    logic            st_addr_we, st_mask_we, st_data_we, st_free;
    logic [IW-1:0]   st_addr_idx, st_mask_idx, st_data_idx, st_free_idx;
    logic [VA_W-1:0] st_vaddr;
    logic [PA_W-1:0] st_paddr;
    logic [15:0]     st_mask;
    logic [127:0]    st_data;
    logic            ld_valid;
    logic [VA_W-1:0] ld_vaddr;
    logic [PA_W-1:0] ld_paddr;
    logic [15:0]     ld_mask;
    logic [N-1:0]    ld_older;
    logic [IW-1:0]   ld_sq_ptr;
    logic [15:0]     s1_fwd_mask, s2_fwd_mask;
    logic            s1_data_inv, s2_data_inv, s2_addr_inv, s2_match_inv;
    logic [127:0]    s2_fwd_data;
    logic [IW-1:0]   s2_data_inv_idx, s2_addr_inv_idx;

    stfwd_unit #(.NUM_ENTRIES(N), .VA_W(VA_W), .PA_W(PA_W)) u_stfwd_unit (.*);

    int    checks = 0;
    int    errors = 0;
    string cur_req = "R11";

    // reference queue
    logic [VA_W-1:0] m_va   [N];
    logic [PA_W-1:0] m_pa   [N];
    logic [15:0]     m_mask [N];
    logic [127:0]    m_data [N];
    bit              m_av   [N];
    bit              m_dv   [N];
    bit              p_v;
    int              p_idx;
    logic [15:0]     p_mask;

    logic [15:0]  e2_mask = '0;
    logic [127:0] e2_data = '0;
    bit           e2_dinv = 0, e2_ainv = 0, e2_minv = 0;
    int           e2_didx = 0, e2_aidx = 0;

    task automatic check_val(string what, logic [127:0] act, logic [127:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s: actual %h expected %h", cur_req, what, act, exp);
        end
    endtask

    task automatic check_s2();
        check_val("s2_fwd_mask", s2_fwd_mask, e2_mask);
        check_val("s2_fwd_data", s2_fwd_data, e2_data);
        check_val("s2_data_inv", s2_data_inv, e2_dinv);
        if (e2_dinv) check_val("s2_data_inv_idx", s2_data_inv_idx, e2_didx);
        check_val("s2_addr_inv", s2_addr_inv, e2_ainv);
        if (e2_ainv) check_val("s2_addr_inv_idx", s2_addr_inv_idx, e2_aidx);
        check_val("s2_match_inv", s2_match_inv, e2_minv);
    endtask

    task automatic eval_and_check_fast();
        logic [15:0]  fm = '0;
        logic [127:0] fd = '0;
        bit di = 0, ai = 0, mi = 0;
        int didx = 0, aidx = 0;
        bit vh [N];
        bit sel [N];
        for (int e = 0; e < N; e++) begin
            bit ph;
            sel[e] = ld_valid && ld_older[e];
            vh[e]  = sel[e] && m_av[e] && (m_mask[e] & ld_mask) != 0 &&
                     m_va[e][VA_W-1:4] == ld_vaddr[VA_W-1:4];
            ph     = sel[e] && m_av[e] && (m_mask[e] & ld_mask) != 0 &&
                     m_pa[e][PA_W-1:4] == ld_paddr[PA_W-1:4];
            if (vh[e] != ph) mi = 1;
        end
        for (int d = 1; d <= N; d++) begin
            int e = (int'(ld_sq_ptr) - d + N) % N;
            if (!di && vh[e] && !m_dv[e]) begin di = 1; didx = e; end
            if (!ai && sel[e] && !m_av[e]) begin ai = 1; aidx = e; end
        end
        for (int b = 0; b < 16; b++) begin
            for (int d = 1; d <= N; d++) begin
                int e = (int'(ld_sq_ptr) - d + N) % N;
                if (vh[e] && m_mask[e][b] && ld_mask[b]) begin
                    if (m_dv[e]) begin
                        fm[b] = 1'b1;
                        fd[8*b +: 8] = m_data[e][8*b +: 8];
                    end
                    break;
                end
            end
        end
        check_val("s1_fwd_mask", s1_fwd_mask, fm);
        check_val("s1_data_inv", s1_data_inv, di);
        e2_mask = fm; e2_data = fd; e2_dinv = di; e2_didx = didx;
        e2_ainv = ai; e2_aidx = aidx; e2_minv = mi;
    endtask

    task automatic model_update();
        if (p_v) m_mask[p_idx] = p_mask;
        p_v = st_mask_we; p_idx = int'(st_mask_idx); p_mask = st_mask;
        if (st_free) begin m_av[st_free_idx] = 0; m_dv[st_free_idx] = 0; end
        if (st_addr_we) begin
            m_av[st_addr_idx] = 1; m_va[st_addr_idx] = st_vaddr; m_pa[st_addr_idx] = st_paddr;
        end
        if (st_data_we) begin m_dv[st_data_idx] = 1; m_data[st_data_idx] = st_data; end
    endtask

    task automatic idle_inputs();
        st_addr_we = 0; st_mask_we = 0; st_data_we = 0; st_free = 0; ld_valid = 0;
    endtask

    // called just after a falling edge with the next inputs already set
    task automatic step();
        #1;
        eval_and_check_fast();
        @(posedge clk);
        model_update();
        @(negedge clk);
        check_s2();
        idle_inputs();
    endtask

    function automatic logic [127:0] pattern(int e);
        logic [127:0] v;
        for (int b = 0; b < 16; b++) v[8*b +: 8] = 8'(e * 16 + b + 1);
        return v;
    endfunction

    task automatic setup(int e, logic [VA_W-1:0] va, logic [PA_W-1:0] pa,
                         logic [15:0] mk, bit with_data);
        st_addr_we = 1; st_addr_idx = IW'(e); st_vaddr = va; st_paddr = pa;
        st_mask_we = 1; st_mask_idx = IW'(e); st_mask = mk;
        st_data_we = with_data; st_data_idx = IW'(e); st_data = pattern(e);
        step();
        step();
        step();
    endtask

    task automatic load(logic [VA_W-1:0] va, logic [PA_W-1:0] pa, logic [15:0] mk,
                        logic [N-1:0] older, int ptr);
        ld_valid = 1; ld_vaddr = va; ld_paddr = pa; ld_mask = mk;
        ld_older = older; ld_sq_ptr = IW'(ptr);
        step();
    endtask

    initial begin
        #(200000 * 10);
        errors++;
        $display("FAIL watchdog: actual hung expected finished");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        for (int e = 0; e < N; e++) begin
            m_av[e] = 0; m_dv[e] = 0; m_va[e] = '0; m_pa[e] = '0;
            m_mask[e] = '0; m_data[e] = '0;
        end
        p_v = 0; p_idx = 0; p_mask = '0;
        idle_inputs();
        st_addr_idx = '0; st_mask_idx = '0; st_data_idx = '0; st_free_idx = '0;
        st_vaddr = '0; st_paddr = '0; st_mask = '0; st_data = '0;
        ld_vaddr = '0; ld_paddr = '0; ld_mask = '0; ld_older = '0; ld_sq_ptr = '0;
        rst = 1;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 0;

        cur_req = "R11";
        check_s2();
        load(16'h1230, 20'h45230, 16'hFFFF, 8'h0C, 4);   // not addressed: idx 3

        cur_req = "R1";
        setup(1, 16'h1230, 20'h45230, 16'h00FF, 1);
        cur_req = "R3";
        load(16'h1238, 20'h45238, 16'h000F, 8'h02, 2);
        load(16'h1240, 20'h45240, 16'h00FF, 8'h02, 2);   // other block

        cur_req = "R4";
        setup(2, 16'h1234, 20'h45234, 16'h0F0F, 1);
        load(16'h1230, 20'h45230, 16'h00FF, 8'h06, 3);   // e2 owns 0-3, e1 owns 4-7
        load(16'h1230, 20'h45230, 16'h00FF, 8'h02, 3);   // e2 not older
        setup(7, 16'h1230, 20'h45230, 16'h000F, 1);
        setup(0, 16'h1230, 20'h45230, 16'h0003, 1);
        load(16'h1230, 20'h45230, 16'h000F, 8'h81, 1);   // wrap: e0 youngest

        cur_req = "R6";
        setup(3, 16'h1230, 20'h45230, 16'h0030, 0);
        load(16'h1230, 20'h45230, 16'hFFFF, 8'h0E, 4);

        cur_req = "R7";
        load(16'h1230, 20'h45230, 16'hFFFF, 8'h1E, 5);   // both flags

        cur_req = "R8";
        setup(5, 16'h1230, 20'h77230, 16'hF000, 1);
        load(16'h1230, 20'h45230, 16'hF00F, 8'h22, 6);

        cur_req = "R9";
        st_mask_we = 1; st_mask_idx = 3'd1; st_mask = 16'hFF00;
        step();
        load(16'h1230, 20'h45230, 16'h000F, 8'h02, 2);   // still old mask
        load(16'h1230, 20'h45230, 16'h000F, 8'h02, 2);   // new mask: no overlap

        cur_req = "R10";
        st_free = 1; st_free_idx = 3'd1;
        step();
        load(16'h1230, 20'h45230, 16'hFF00, 8'h02, 2);

        cur_req = "R2";
        ld_vaddr = 16'h1230; ld_paddr = 20'h45230; ld_mask = 16'hFFFF;
        ld_older = 8'hFF; ld_sq_ptr = 3'd0;
        step();
        step();

        cur_req = "R5";
        for (int t = 0; t < 400; t++) begin
            int e = $urandom_range(0, N - 1);
            logic [VA_W-1:0] va = {11'h091, 1'($urandom_range(0, 1)), 4'($urandom)};
            logic [PA_W-1:0] pa = {4'h4, va[15:4] ^ {11'h0, 1'($urandom_range(0, 7) == 0)}, va[3:0]};
            case ($urandom_range(0, 5))
                0: begin st_addr_we = 1; st_addr_idx = IW'(e); st_vaddr = va; st_paddr = pa; end
                1: begin st_mask_we = 1; st_mask_idx = IW'(e); st_mask = 16'($urandom); end
                2: begin st_data_we = 1; st_data_idx = IW'(e);
                         st_data = {$urandom, $urandom, $urandom, $urandom}; end
                3: begin st_free = 1; st_free_idx = IW'(e); end
                default: ;
            endcase
            ld_valid = ($urandom_range(0, 3) != 0);
            ld_vaddr = {11'h091, 1'($urandom_range(0, 1)), 4'h0};
            ld_paddr = {4'h4, ld_vaddr[15:4], 4'h0};
            ld_mask = 16'($urandom);
            ld_older = 8'($urandom);
            ld_sq_ptr = IW'($urandom);
            step();
        end

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule